// File: doc/BRIEF.md
# Binary Early/Late Clock-Recovery Phase Detector

This block is the phase-comparison stage of a clock and data recovery loop. It takes a serial line and one recovery clock that runs at the bit rate. The rising edge of the clock is meant to sit in the centre of each bit. The falling edge sits on the boundary between two bits. Each bit is therefore sampled twice: once on the rising edge, which gives the data decision, and once on the falling edge, which gives the edge probe.

The block can only decide about phase when two consecutive centre samples differ. In that case the edge probe shows on which side of the real transition the clock lies. The block then raises a one-bit-period pulse on `up_o` or on `dn_o`. These outputs control an external charge pump: `up_o` makes it source current, `dn_o` makes it sink current, and both low leaves it tristated. When the loop settles, the recovered edge lines up with the data transitions and the rising edge falls in the middle of the eye.

The centre sample is also passed out as the retimed data bit. The serial line cannot be stalled, so the ports carry no valid/ready handshake. One result is produced every clock cycle.

Top module: `bangbang_pd`

## Requirements
- R1: The serial input is captured on every rising clock edge. That value appears on `rdata_o` from that edge until the next rising edge.
- R2: The edge probe is the value of the serial input captured on the falling clock edge. This is the edge that lies between the two rising-edge samples it is compared with.
- R3: When two consecutive rising-edge samples are equal, `up_o` and `dn_o` are both low for the matching output cycle.
- R4: When consecutive rising-edge samples differ and the edge probe between them equals the newer sample, the clock is late. `dn_o` is 1 and `up_o` is 0.
- R5: When consecutive rising-edge samples differ and the edge probe between them equals the older sample, the clock is early. `up_o` is 1 and `dn_o` is 0.
- R6: The decision is registered. Take a transition between the sample captured at rising edge k-1 and the sample captured at edge k. Its pulse is present from edge k+1 until edge k+2, which is exactly one bit period. Transitions on back-to-back bits give back-to-back pulses.
- R7: `up_o` and `dn_o` are never 1 in the same cycle.
- R8: `rst_ni` is asynchronous and active low. While it is low, `up_o`, `dn_o` and `rdata_o` are 0. After release, no pulse is produced until two rising-edge samples have been taken. The reset value therefore never counts as a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate recovery clock; rising edge = bit centre, falling edge = bit boundary |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial data line |
| up_o | output | 1 | Charge pump source command (clock early) |
| dn_o | output | 1 | Charge pump sink command (clock late) |
| rdata_o | output | 1 | Retimed data bit (centre sample) |

## Verification
The assertions check the following on every cycle:
- the two pump commands are never active together;
- there is no pulse unless the previous cycle held a transition;
- the direction of each pulse agrees with the edge probe that produced it;
- the retimed bit follows the input with one cycle of delay;
- nothing fires before two samples have been taken after reset.

Some behaviour can only be shown by the bench scenarios. These drive the line with its transitions placed at set offsets before and after the falling edge. They show that the sign of the decision actually follows the data phase. They show that a phase just past the boundary gives the opposite sign to one just before it. They also show the exact cycle on which each pulse appears, and that a first bit of 1 right after reset gives no pulse.

// File: rtl/bangbang_pd_pkg.sv
package bangbang_pd_pkg;

  // charge pump command: bit 0 sources (up), bit 1 sinks (down)
  typedef enum logic [1:0] {
    PUMP_HIZ  = 2'b00,
    PUMP_SRC  = 2'b01,
    PUMP_SINK = 2'b10
  } pump_cmd_e;

  localparam int unsigned PRIME_SAMPLES = 2;

endpackage

// File: rtl/bangbang_pd_sampler.sv
module bangbang_pd_sampler
  import bangbang_pd_pkg::*;
#(
  parameter int unsigned PRIME_N = PRIME_SAMPLES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_i,
  output logic cen_new_o,
  output logic cen_old_o,
  output logic edge_o,
  output logic primed_o
);

  localparam int unsigned CW = (PRIME_N < 2) ? 1 : $clog2(PRIME_N + 1);

  logic          edge_fall_q;
  logic          edge_q;
  logic          cen_new_q;
  logic          cen_old_q;
  logic [CW-1:0] seen_q;

  // boundary probe on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_fall_q <= 1'b0;
    else         edge_fall_q <= ser_i;
  end

  // centre samples and retiming of the boundary probe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_new_q <= 1'b0;
      cen_old_q <= 1'b0;
      edge_q    <= 1'b0;
    end else begin
      cen_new_q <= ser_i;
      cen_old_q <= cen_new_q;
      edge_q    <= edge_fall_q;
    end
  end

  // count centre samples since reset, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     seen_q <= '0;
    else if (seen_q != CW'(PRIME_N)) seen_q <= seen_q + 1'b1;
  end

  assign cen_new_o = cen_new_q;
  assign cen_old_o = cen_old_q;
  assign edge_o    = edge_q;
  assign primed_o  = (seen_q == CW'(PRIME_N));

  // R1
  retime_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (cen_new_q == $past(ser_i)));

  // R8
  prime_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(primed_o) |-> primed_o);

endmodule

// File: rtl/bangbang_pd_decide.sv
module bangbang_pd_decide
  import bangbang_pd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cen_new_i,
  input  logic      cen_old_i,
  input  logic      edge_i,
  input  logic      primed_i,
  output pump_cmd_e cmd_o
);

  logic      trans;
  pump_cmd_e cmd_d;
  pump_cmd_e cmd_q;

  assign trans = primed_i & (cen_new_i ^ cen_old_i);

  always_comb begin
    cmd_d = PUMP_HIZ;
    if (trans) begin
      if (edge_i == cen_new_i) cmd_d = PUMP_SINK;  // late
      else                     cmd_d = PUMP_SRC;   // early
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= PUMP_HIZ;
    else         cmd_q <= cmd_d;
  end

  assign cmd_o = cmd_q;

  // R7
  cmd_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q != 2'b11);

  // R8
  no_early_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(primed_i) |-> (cmd_q == PUMP_HIZ));

endmodule

// File: rtl/bangbang_pd.sv
module bangbang_pd
  import bangbang_pd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_i,
  output logic up_o,
  output logic dn_o,
  output logic rdata_o
);

  logic      cen_new;
  logic      cen_old;
  logic      edge_s;
  logic      primed;
  pump_cmd_e cmd;

  bangbang_pd_sampler #(.PRIME_N(PRIME_SAMPLES)) u_smp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_i     (ser_i),
    .cen_new_o (cen_new),
    .cen_old_o (cen_old),
    .edge_o    (edge_s),
    .primed_o  (primed)
  );

  bangbang_pd_decide u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cen_new_i (cen_new),
    .cen_old_i (cen_old),
    .edge_i    (edge_s),
    .primed_i  (primed),
    .cmd_o     (cmd)
  );

  assign up_o    = cmd[0];
  assign dn_o    = cmd[1];
  assign rdata_o = cen_new;

  // R7
  never_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));

  // R3
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cen_new == cen_old) |-> (!up_o && !dn_o));

  // R4
  late_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_o |-> $past(edge_s == cen_new));

  // R5
  early_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |-> $past(edge_s == cen_old));

endmodule

// File: tb/sim_bangbang_pd.sv
`timescale 1ns/100ps
module sim_bangbang_pd;

  typedef struct {
    logic rd;
    logic up;
    logic dn;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 1'b0;
  logic up, dn, rdata;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  exp_t pend;
  bit   pend_v = 0;
  logic last_bit = 1'b0;
  bit   have_prev = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  bangbang_pd u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .ser_i   (ser),
    .up_o    (up),
    .dn_o    (dn),
    .rdata_o (rdata)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // driver: bit driven at posedge + ph ns; ph < 4 means transition precedes the falling-edge probe
  task automatic drive_bit(int ph, logic b, string req);
    exp_t e;
    @(posedge clk);
    #(ph);
    e.rd = b;
    e.req = req;
    e.up = 1'b0;
    e.dn = 1'b0;
    if (have_prev && b != last_bit) begin
      if (ph < 4) e.dn = 1'b1;
      else        e.up = 1'b1;
    end
    q.push_back(e);
    ser = b;
    last_bit = b;
    have_prev = 1;
  endtask

  task automatic drive_pat(int ph, logic [31:0] pat, int n, string req);
    for (int i = 0; i < n; i++) drive_bit(ph, pat[i], req);
  endtask

  // monitor: 0.5 ns after each rising edge
  always @(posedge clk) begin
    #0.5;
    if (rst_n) begin
      if (pend_v) begin
        chk(pend.req, "up_o", up, pend.up);
        chk(pend.req, "dn_o", dn, pend.dn);
        chk("R7", "up&dn", up & dn, 1'b0);
        pend_v = 0;
      end
      if (q.size() > 0) begin
        pend = q.pop_front();
        chk("R1", "rdata_o", rdata, pend.rd);
        pend_v = 1;
      end
    end
  end

  initial begin
    exp_t e0;
    ser = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "up_o in reset", up, 1'b0);
    chk("R8", "dn_o in reset", dn, 1'b0);
    chk("R8", "rdata_o in reset", rdata, 1'b0);
    // first bit is 1 while the reset value is 0: no pulse may follow (R8)
    e0.rd = 1'b1; e0.up = 1'b0; e0.dn = 1'b0; e0.req = "R8";
    q.push_back(e0);
    last_bit = 1'b1;
    have_prev = 1;
    @(negedge clk);
    #1 rst_n = 1'b1;
    // R4: transitions ahead of the probe -> late -> dn
    drive_pat(2, 32'b0000_0000_0000_0000_0000_0001_0110_1010, 12, "R4");
    // R5: transitions after the probe -> early -> up
    drive_pat(6, 32'b0000_0000_0000_0000_0000_1001_0101_1100, 12, "R5");
    // R2: just either side of the falling edge
    drive_pat(3, 32'b0000_0000_0000_0000_0000_0000_0101_0101, 8, "R2");
    drive_pat(5, 32'b0000_0000_0000_0000_0000_0000_1010_1010, 8, "R2");
    // R6: alternating bits give back-to-back pulses at extreme phases
    drive_pat(1, 32'b0000_0000_0000_0000_0000_0000_0101_0101, 8, "R6");
    drive_pat(7, 32'b0000_0000_0000_0000_0000_0000_1010_1010, 8, "R6");
    // R3: long runs with no transition -> tristate
    drive_pat(2, 32'h0000_0000, 10, "R3");
    drive_pat(6, 32'hFFFF_FFFF, 10, "R3");
    drive_pat(6, 32'b0000_0000_0000_0000_0000_0000_1100_0111, 8, "R5");
    repeat (4) @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule